// File: doc/BRIEF.md
# One-Bit Control Processor Core

This block is a single-bit processor core for decision-style control. On each clock period it takes one 4-bit instruction and combines one bit from the data line with a one-bit result register. The result stays in that register. The core also drives a set of single-cycle control flags. An outside sequencer reacts to these flags to jump, return or mark program points. The program counter, the program memory and any address decoding sit outside the core.

The data line is modelled by three ports: a data input, a registered data output and a write strobe. An external buffer would use the strobe as its drive enable. Two enable latches gate the traffic. The input enable forces the data read to 0 when it is clear. The output enable blocks the store instructions when it is clear. A skip state lets one instruction cancel the next one completely.

All state changes and the capture of the instruction happen on the falling edge of `clk`. Every output is registered and holds for one full period after the falling edge that executed its instruction.

Top module: `bitctl_core`

## Requirements
- R1: While `rst` is high at a falling edge, the core clears the result register, both enable latches, the skip state, `data_o`, `wr_o` and all four flags.
- R2: Pin `instr_pins_i[i]` carries opcode bit 3-i. Opcodes are written MSB first, so opcode 0010 is presented as pins 4'b0100. The opcode values are: 0 mark-O, 1 load, 2 load-inverse, 3 AND, 4 AND-inverse, 5 OR, 6 OR-inverse, 7 XNOR, 8 store, 9 store-inverse, 10 input-enable, 11 output-enable, 12 jump, 13 return, 14 skip-if-zero, 15 mark-F.
- R3: Opcodes 0, 15, 12 and 13 each raise exactly one flag: `flago_o`, `flagf_o`, `jump_o` and `ret_o` respectively. The flag is raised for the single period after the executing edge. No other opcode raises a flag.
- R4: Load writes the read bit into the result register. Load-inverse writes its complement.
- R5: The logic opcodes replace the result with result AND bit, result AND NOT bit, result OR bit, result OR NOT bit, or result XNOR bit.
- R6: While the input-enable latch is 0, the read bit is 0 for every load and logic opcode. Input-enable and output-enable copy the ungated `data_i` into their latches.
- R7: When the output-enable latch is 1, store sets `data_o` to the result and store-inverse sets it to the complement, and `wr_o` is high for that one period. When the latch is 0, `wr_o` stays low and `data_o` keeps its value.
- R8: The return opcode always cancels the next instruction.
- R9: Skip-if-zero cancels the next instruction when the result register is 0 and has no effect when it is 1.
- R10: A cancelled instruction changes no register and raises no flag or strobe. A cancelled return or skip-if-zero does not cancel the instruction after it.
- R11: One instruction completes every clock period. Its outputs appear after the falling edge that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the core acts on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_pins_i | input | 4 | Instruction pins, bit order reversed from the opcode |
| data_i | input | 1 | Data line as read by the core |
| data_o | output | 1 | Data line value driven by the store opcodes |
| wr_o | output | 1 | Write strobe for one period after an enabled store |
| jump_o | output | 1 | Jump request flag |
| ret_o | output | 1 | Return request flag |
| flago_o | output | 1 | Mark-O flag |
| flagf_o | output | 1 | Mark-F flag |

## Verification
A pending skip and an instruction that would otherwise raise a flag or a write strobe can land in the same cycle. In that cycle the skip must win. The bench provokes this by putting a return directly before an enabled store, a mark-F and a second return, and by putting a zero-result skip-if-zero before mark-O. Each cycle is judged against a behavioural model: the strobe and flags must stay low and `data_o` must hold. A later store must also show that the result register did not change.

// File: rtl/bitctl_pkg.sv
package bitctl_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_MARK_O    = 4'd0,
    OP_LOAD      = 4'd1,
    OP_LOAD_INV  = 4'd2,
    OP_AND       = 4'd3,
    OP_AND_INV   = 4'd4,
    OP_OR        = 4'd5,
    OP_OR_INV    = 4'd6,
    OP_XNOR      = 4'd7,
    OP_STORE     = 4'd8,
    OP_STORE_INV = 4'd9,
    OP_IN_EN     = 4'd10,
    OP_OUT_EN    = 4'd11,
    OP_JUMP      = 4'd12,
    OP_RETURN    = 4'd13,
    OP_SKIP_Z    = 4'd14,
    OP_MARK_F    = 4'd15
  } op_e;

  typedef struct packed {
    op_e  op;
    logic rr_wr;
    logic store;
    logic store_inv;
    logic set_ien;
    logic set_oen;
    logic jump;
    logic ret;
    logic mark_o;
    logic mark_f;
    logic skip_always;
    logic skip_if_zero;
  } ctl_t;
endpackage

// File: rtl/bitctl_decode.sv
module bitctl_decode
  import bitctl_pkg::*;
#(
  parameter int W = OPW
) (
  input  logic [W-1:0] pins_i,
  input  logic         squash_i,
  output ctl_t         ctl_o
);
  logic [W-1:0] op_bits;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign op_bits[i] = pins_i[W-1-i];
  end

  always_comb begin
    ctl_o    = '0;
    ctl_o.op = op_e'(op_bits);
    if (!squash_i) begin
      unique case (op_e'(op_bits))
        OP_MARK_O:    ctl_o.mark_o       = 1'b1;
        OP_LOAD, OP_LOAD_INV, OP_AND, OP_AND_INV,
        OP_OR, OP_OR_INV, OP_XNOR:
                      ctl_o.rr_wr        = 1'b1;
        OP_STORE:     ctl_o.store        = 1'b1;
        OP_STORE_INV: ctl_o.store_inv    = 1'b1;
        OP_IN_EN:     ctl_o.set_ien      = 1'b1;
        OP_OUT_EN:    ctl_o.set_oen      = 1'b1;
        OP_JUMP:      ctl_o.jump         = 1'b1;
        OP_RETURN: begin
                      ctl_o.ret          = 1'b1;
                      ctl_o.skip_always  = 1'b1;
        end
        OP_SKIP_Z:    ctl_o.skip_if_zero = 1'b1;
        OP_MARK_F:    ctl_o.mark_f       = 1'b1;
        default:      ctl_o.mark_o       = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/bitctl_lu.sv
module bitctl_lu
  import bitctl_pkg::*;
(
  input  op_e  fn_i,
  input  logic rr_i,
  input  logic bit_i,
  output logic rr_o
);
  always_comb begin
    unique case (fn_i)
      OP_LOAD:     rr_o = bit_i;
      OP_LOAD_INV: rr_o = ~bit_i;
      OP_AND:      rr_o = rr_i & bit_i;
      OP_AND_INV:  rr_o = rr_i & ~bit_i;
      OP_OR:       rr_o = rr_i | bit_i;
      OP_OR_INV:   rr_o = rr_i | ~bit_i;
      OP_XNOR:     rr_o = ~(rr_i ^ bit_i);
      default:     rr_o = rr_i;
    endcase
  end
endmodule

// File: rtl/bitctl_flags.sv
module bitctl_flags
  import bitctl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ctl_t ctl_i,
  output logic jump_o,
  output logic ret_o,
  output logic flago_o,
  output logic flagf_o
);
  always_ff @(negedge clk) begin
    if (rst) begin
      jump_o  <= 1'b0;
      ret_o   <= 1'b0;
      flago_o <= 1'b0;
      flagf_o <= 1'b0;
    end else begin
      jump_o  <= ctl_i.jump;
      ret_o   <= ctl_i.ret;
      flago_o <= ctl_i.mark_o;
      flagf_o <= ctl_i.mark_f;
    end
  end

  AST_FLAGS_ONEHOT: assert property (@(negedge clk) disable iff (rst)
    $onehot0({jump_o, ret_o, flago_o, flagf_o})); // R3
endmodule

// File: rtl/bitctl_core.sv
module bitctl_core
  import bitctl_pkg::*;
#(
  parameter int W = OPW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] instr_pins_i,
  input  logic         data_i,
  output logic         data_o,
  output logic         wr_o,
  output logic         jump_o,
  output logic         ret_o,
  output logic         flago_o,
  output logic         flagf_o
);
  logic rr_q, ien_q, oen_q, skip_q;
  logic rr_nxt, bit_rd;
  ctl_t ctl;

  assign bit_rd = ien_q & data_i;

  bitctl_decode #(.W(W)) u_dec (
    .pins_i   (instr_pins_i),
    .squash_i (skip_q),
    .ctl_o    (ctl)
  );

  bitctl_lu u_lu (
    .fn_i  (ctl.op),
    .rr_i  (rr_q),
    .bit_i (bit_rd),
    .rr_o  (rr_nxt)
  );

  bitctl_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .ctl_i   (ctl),
    .jump_o  (jump_o),
    .ret_o   (ret_o),
    .flago_o (flago_o),
    .flagf_o (flagf_o)
  );

  always_ff @(negedge clk) begin
    if (rst) begin
      rr_q   <= 1'b0;
      ien_q  <= 1'b0;
      oen_q  <= 1'b0;
      skip_q <= 1'b0;
      data_o <= 1'b0;
      wr_o   <= 1'b0;
    end else begin
      skip_q <= ctl.skip_always | (ctl.skip_if_zero & ~rr_q);
      wr_o   <= 1'b0;
      if (ctl.rr_wr)   rr_q  <= rr_nxt;
      if (ctl.set_ien) ien_q <= data_i;
      if (ctl.set_oen) oen_q <= data_i;
      if ((ctl.store | ctl.store_inv) & oen_q) begin
        data_o <= rr_q ^ ctl.store_inv;
        wr_o   <= 1'b1;
      end
    end
  end

  AST_SKIP_SILENT: assert property (@(negedge clk) disable iff (rst)
    skip_q |=> !(wr_o || jump_o || ret_o || flago_o || flagf_o)); // R10
  AST_SKIP_RR_HOLD: assert property (@(negedge clk) disable iff (rst)
    skip_q |=> $stable(rr_q)); // R10
  AST_WR_NEEDS_OEN: assert property (@(negedge clk) disable iff (rst)
    wr_o |-> $past(oen_q)); // R7
  AST_DOUT_HOLD: assert property (@(negedge clk) disable iff (rst)
    !wr_o |-> $stable(data_o)); // R7
  AST_RET_ARMS_SKIP: assert property (@(negedge clk) disable iff (rst)
    ret_o |-> skip_q); // R8
endmodule

// File: tb/bitctl_core_tb.sv
module bitctl_core_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] instr_pins = 4'b0;
  logic data_i = 1'b0;
  logic data_o, wr_o, jump_o, ret_o, flago_o, flagf_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural reference state
  bit m_rr, m_ien, m_oen, m_skip, m_dout;
  bit e_wr, e_j, e_r, e_fo, e_ff;

  always #10 clk = ~clk;

  bitctl_core u_dut (
    .clk(clk), .rst(rst), .instr_pins_i(instr_pins), .data_i(data_i),
    .data_o(data_o), .wr_o(wr_o), .jump_o(jump_o), .ret_o(ret_o),
    .flago_o(flago_o), .flagf_o(flagf_o)
  );

  function automatic logic [3:0] to_pins(input int op);
    logic [3:0] o;
    o = op[3:0];
    return {o[0], o[1], o[2], o[3]};
  endfunction

  task automatic compare(input string tag);
    logic [5:0] act, exp;
    act = {data_o, wr_o, jump_o, ret_o, flago_o, flagf_o};
    exp = {m_dout, e_wr, e_j, e_r, e_fo, e_ff};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {dout,wr,jmp,ret,fo,ff} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic model(input int op, input bit din);
    bit d;
    e_wr = 0; e_j = 0; e_r = 0; e_fo = 0; e_ff = 0;
    if (m_skip) begin
      m_skip = 0;
      return;
    end
    d = m_ien ? din : 1'b0;
    case (op)
      0:  e_fo = 1;
      1:  m_rr = d;
      2:  m_rr = !d;
      3:  m_rr = m_rr && d;
      4:  m_rr = m_rr && !d;
      5:  m_rr = m_rr || d;
      6:  m_rr = m_rr || !d;
      7:  m_rr = (m_rr == d);
      8:  if (m_oen) begin m_dout = m_rr;  e_wr = 1; end
      9:  if (m_oen) begin m_dout = !m_rr; e_wr = 1; end
      10: m_ien = din;
      11: m_oen = din;
      12: e_j = 1;
      13: begin e_r = 1; m_skip = 1; end
      14: if (!m_rr) m_skip = 1;
      default: e_ff = 1;
    endcase
  endtask

  task automatic step(input int op, input bit din, input string tag);
    model(op, din);
    instr_pins = to_pins(op);
    data_i     = din;
    @(posedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    instr_pins = to_pins(0);
    repeat (2) @(posedge clk);
    m_rr = 0; m_ien = 0; m_oen = 0; m_skip = 0; m_dout = 0;
    e_wr = 0; e_j = 0; e_r = 0; e_fo = 0; e_ff = 0;
    compare(tag);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(posedge clk);
    do_reset("R1 reset state");
    step(10, 1, "R6 input enable set");
    step(11, 1, "R6 output enable set");
    step(1, 1, "R4 load 1");
    step(8, 0, "R7 store 1");
    step(2, 1, "R4 load inverse of 1");
    step(8, 0, "R7 store 0");
    step(9, 0, "R7 store inverse");
    // R2: pins 0100 must decode as load-inverse, not AND-inverse
    step(1, 0, "R2 clear result");
    step(2, 0, "R2 reversed pins load-inverse");
    step(8, 0, "R2 store after reversed opcode");
    for (int op = 3; op <= 7; op++)
      for (int r = 0; r < 2; r++)
        for (int d = 0; d < 2; d++) begin
          step(1, r[0], "R5 preset result");
          step(op, d[0], "R5 logic op");
          step(8, 0, "R5 store logic result");
        end
    step(0, 0, "R3 mark-O flag");
    step(15, 0, "R3 mark-F flag");
    step(12, 0, "R3 jump flag");
    step(12, 0, "R3 back-to-back jump");
    step(1, 0, "R11 flags drop next period");
    step(10, 0, "R6 input enable cleared");
    step(1, 1, "R6 gated load reads 0");
    step(8, 0, "R6 store gated result");
    step(6, 1, "R6 gated OR-inverse");
    step(8, 0, "R6 store OR-inverse");
    step(10, 1, "R6 input enable set again");
    step(11, 0, "R7 output enable cleared");
    step(1, 0, "R7 load 0");
    step(8, 0, "R7 store blocked");
    step(9, 0, "R7 store inverse blocked");
    step(11, 1, "R7 output enable set again");
    step(1, 1, "R8 load 1");
    step(13, 0, "R8 return flag");
    step(9, 0, "R8 skipped store");
    step(13, 0, "R8 return again");
    step(15, 0, "R10 skipped mark-F");
    step(13, 0, "R10 return before return");
    step(13, 0, "R10 skipped return");
    step(8, 0, "R10 no chained skip");
    step(1, 0, "R9 load 0");
    step(14, 0, "R9 skip on zero");
    step(0, 0, "R9 skipped mark-O");
    step(1, 1, "R9 load 1");
    step(14, 0, "R9 no skip on one");
    step(0, 0, "R9 mark-O runs");
    step(13, 0, "R10 return");
    step(1, 0, "R10 skipped load");
    step(8, 0, "R10 result unchanged");
    step(13, 0, "R10 return");
    step(10, 0, "R10 skipped input enable");
    step(1, 1, "R10 input still enabled");
    step(8, 0, "R10 store shows enable kept");
    step(1, 0, "R9 load 0");
    step(14, 0, "R9 skip on zero");
    step(14, 0, "R10 skipped skip-if-zero");
    step(0, 0, "R10 mark-O not chained");
    for (int k = 0; k < 400; k++)
      step(int'($urandom_range(15, 0)), bit'($urandom_range(1, 0)), "R11 random stream");
    step(13, 0, "R1 return before reset");
    do_reset("R1 reset clears skip");
    step(0, 0, "R1 mark-O after reset");
    step(8, 0, "R1 output enable cleared by reset");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule